// File: doc/BRIEF.md
# Machine-Cycle Bus Timing Controller

This block runs the clock-by-clock sequence of one machine cycle on the external bus of an 8-bit processor with a 16-bit address. The core hands it a cycle request: a cycle kind, an address, write data, and a flag that says the core is halted. The block then steps through four states. T1 announces the cycle. T2 starts the transfer. Zero or more wait states (TW) stretch the transfer. T3 completes it. During T1 a status byte describing the cycle is driven on the data outputs, and a one-clock SYNC pulse marks the start.

Wait states are added for as long as READY is low. An external bus master may request the bus with HOLD. The request is granted only in a window where the current transfer is known to finish, or while the core is halted. When it is granted, the controller raises HLDA and releases the address and data drivers through output-enable signals. The data bus is split into a separate input and output with an enable, so pad logic builds the tri-state buffer.

A single-phase clock is used.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: A request accepted in the idle state (`req_take_o` high) starts T1 on the next clock. In T1, `sync_o` is high for exactly one clock and the latched address is driven with `addr_oe_o` high.
- R2: In T1, `data_oe_o` is high and `data_o` carries the status byte. The bit meanings are: bit7 memory read, bit6 input, bit5 opcode fetch, bit4 output, bit3 halt acknowledge, bit2 stack, bit1 memory write, bit0 interrupt acknowledge. The values per kind code are: 0 fetch=A0h, 1 memory read=80h, 2 memory write=02h, 3 input=40h, 4 output=10h, 5 stack read=84h, 6 stack write=06h, 7 interrupt acknowledge=21h, 8 halt acknowledge=88h.
- R3: If `ready_i` is low at the end of T2 or TW, the next clock is TW, so N sampled low values give N wait clocks. `wait_o` is high in exactly those clocks.
- R4: For read-class kinds (0, 1, 3, 5, 7, 8), `dbin_o` is high in T2, TW and T3. `data_i` is captured at the end of T3 and appears on `rdata_o`, with `done_o` high for one clock, in the clock after T3.
- R5: For write-class kinds (2, 4, 6), the write data is driven with `data_oe_o` high from T2 through T3. `wr_no` is low only in T3. `done_o` follows T3 as for reads.
- R6: `hold_i` is accepted only at the end of T2 or TW when `ready_i` is high, or while halted. A `hold_i` that is high only in idle, T1, or stalled clocks has no effect on `hlda_o`.
- R7: After a hold is accepted in a cycle, `hlda_o` rises in T3 for read-class kinds, and in the clock after T3 for write-class kinds.
- R8: While `hlda_o` is high, `addr_oe_o` and `data_oe_o` are low, `wr_no` is high, and no new cycle is accepted (`req_take_o` and `sync_o` low).
- R9: When `hold_i` is low at a clock edge in the hold state, `hlda_o` falls on that edge. The drivers stay disabled until the T1 of the next accepted cycle.
- R10: An asynchronous reset (`rst_ni` low) clears `hlda_o` at once and returns the controller to idle with all output enables low and `wr_no` high.
- R11: With `halt_i` high and no request in idle, the controller enters a halted state. A `hold_i` there gives `hlda_o` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Core cycle request |
| req_kind_i | input | 4 | Cycle kind code (see R2) |
| req_addr_i | input | ADDR_W | Cycle address |
| req_wdata_i | input | 8 | Write data |
| halt_i | input | 1 | Core is halted |
| ready_i | input | 1 | Transfer may complete |
| hold_i | input | 1 | External bus request |
| data_i | input | 8 | Data bus input |
| req_take_o | output | 1 | Request accepted this clock |
| addr_o | output | ADDR_W | Address bus value |
| addr_oe_o | output | 1 | Address driver enable |
| data_o | output | 8 | Data bus output value |
| data_oe_o | output | 1 | Data driver enable |
| sync_o | output | 1 | First clock of a machine cycle |
| dbin_o | output | 1 | Data bus in input mode |
| wr_no | output | 1 | Write strobe, active low |
| wait_o | output | 1 | Wait state in progress |
| hlda_o | output | 1 | Hold acknowledge |
| done_o | output | 1 | Cycle complete pulse |
| rdata_o | output | 8 | Captured read data |

## Verification
The main sequencing is run with every cycle kind and with zero to several wait clocks. This separates the status encoding, the read/write class split and the wait-state count. Four hold patterns are used on each class:
- no hold;
- a granted hold;
- a hold present only in idle and T1;
- a hold present only during stalled clocks.

Together these show whether acceptance is tied to the correct window, and whether the HLDA start differs between reads and writes. A randomized run of stalls and holds, together with a halted-state hold and a reset during hold, confirms that no cycle starts and no write strobe falls while the bus is released.

// File: rtl/bus_ctrl_pkg.sv
`timescale 1ns/1ps
package bus_ctrl_pkg;
  localparam int DATA_W = 8;
  localparam int KIND_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_HALT, ST_HOLD
  } tstate_e;

  localparam logic [KIND_W-1:0] K_FETCH  = 4'd0;
  localparam logic [KIND_W-1:0] K_MEM_RD = 4'd1;
  localparam logic [KIND_W-1:0] K_MEM_WR = 4'd2;
  localparam logic [KIND_W-1:0] K_IO_IN  = 4'd3;
  localparam logic [KIND_W-1:0] K_IO_OUT = 4'd4;
  localparam logic [KIND_W-1:0] K_STK_RD = 4'd5;
  localparam logic [KIND_W-1:0] K_STK_WR = 4'd6;
  localparam logic [KIND_W-1:0] K_INTA   = 4'd7;
  localparam logic [KIND_W-1:0] K_HALTA  = 4'd8;

  // status bit positions
  localparam int SB_MEMR  = 7;
  localparam int SB_INP   = 6;
  localparam int SB_FETCH = 5;
  localparam int SB_OUT   = 4;
  localparam int SB_HLTA  = 3;
  localparam int SB_STACK = 2;
  localparam int SB_MEMW  = 1;
  localparam int SB_INTA  = 0;
endpackage

// File: rtl/bus_cycle_decode.sv
`timescale 1ns/1ps
module bus_cycle_decode
  import bus_ctrl_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  output logic [DATA_W-1:0] status_o,
  output logic              rd_cls_o,
  output logic              wr_cls_o
);
  always_comb begin
    status_o = '0;
    unique case (kind_i)
      K_FETCH:  begin status_o[SB_MEMR] = 1'b1; status_o[SB_FETCH] = 1'b1; end
      K_MEM_WR: status_o[SB_MEMW] = 1'b1;
      K_IO_IN:  status_o[SB_INP]  = 1'b1;
      K_IO_OUT: status_o[SB_OUT]  = 1'b1;
      K_STK_RD: begin status_o[SB_MEMR] = 1'b1; status_o[SB_STACK] = 1'b1; end
      K_STK_WR: begin status_o[SB_MEMW] = 1'b1; status_o[SB_STACK] = 1'b1; end
      K_INTA:   begin status_o[SB_FETCH] = 1'b1; status_o[SB_INTA] = 1'b1; end
      K_HALTA:  begin status_o[SB_MEMR] = 1'b1; status_o[SB_HLTA] = 1'b1; end
      default:  status_o[SB_MEMR] = 1'b1;  // mem read, also unused codes
    endcase
  end

  assign wr_cls_o = status_o[SB_MEMW] | status_o[SB_OUT];
  assign rd_cls_o = ~wr_cls_o;
endmodule

// File: rtl/bus_tstate_fsm.sv
`timescale 1ns/1ps
module bus_tstate_fsm
  import bus_ctrl_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_valid_i,
  input  logic    halt_i,
  input  logic    ready_i,
  input  logic    hold_i,
  output tstate_e state_o,
  output logic    hold_pend_o,
  output logic    take_o
);
  tstate_e st_q, st_d;
  logic    pend_q;
  logic    in_xfer;

  assign in_xfer = (st_q == ST_T2) || (st_q == ST_TW);
  assign take_o  = (st_q == ST_IDLE) && req_valid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_T1;
               else if (halt_i) st_d = ST_HALT;
      ST_T1:   st_d = ST_T2;
      ST_T2,
      ST_TW:   st_d = ready_i ? ST_T3 : ST_TW;
      ST_T3:   st_d = pend_q ? ST_HOLD : ST_IDLE;
      ST_HALT: if (hold_i) st_d = ST_HOLD;
               else if (!halt_i) st_d = ST_IDLE;
      ST_HOLD: if (!hold_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      // grant window: transfer ends this edge
      if (in_xfer && ready_i && hold_i) pend_q <= 1'b1;
      else if (st_q == ST_T3)          pend_q <= 1'b0;
    end
  end

  assign state_o     = st_q;
  assign hold_pend_o = pend_q;

  AST_HOLD_FROM_T3_OR_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_HOLD) |-> ($past(st_q) inside {ST_T3, ST_HALT, ST_HOLD})) else $error("hold entry"); // R6
endmodule

// File: rtl/bus_pin_drive.sv
`timescale 1ns/1ps
module bus_pin_drive
  import bus_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tstate_e           state_i,
  input  logic              hold_pend_i,
  input  logic              rd_cls_i,
  input  logic              wr_cls_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              sync_o,
  output logic              dbin_o,
  output logic              wr_no,
  output logic              wait_o,
  output logic              hlda_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic in_t1, in_t3, xfer_ph, active;
  logic done_q;
  logic [DATA_W-1:0] rdata_q;

  assign in_t1   = (state_i == ST_T1);
  assign in_t3   = (state_i == ST_T3);
  assign xfer_ph = (state_i == ST_T2) || (state_i == ST_TW) || in_t3;
  assign active  = in_t1 || xfer_ph;

  // read cycles free the bus at T3, writes one clock later
  assign hlda_o    = (state_i == ST_HOLD) || (in_t3 && hold_pend_i && rd_cls_i);
  assign addr_oe_o = active && !hlda_o;
  assign addr_o    = addr_i;
  assign data_oe_o = in_t1 || (wr_cls_i && xfer_ph);
  assign data_o    = in_t1 ? status_i : wdata_i;
  assign sync_o    = in_t1;
  assign dbin_o    = rd_cls_i && xfer_ph;
  assign wr_no     = !(wr_cls_i && in_t3);
  assign wait_o    = (state_i == ST_TW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= in_t3;
      if (in_t3 && rd_cls_i) rdata_q <= data_i;
    end
  end

  assign done_o  = done_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/bus_cycle_ctrl.sv
`timescale 1ns/1ps
module bus_cycle_ctrl
  import bus_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [KIND_W-1:0] req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              halt_i,
  input  logic              ready_i,
  input  logic              hold_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_take_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              sync_o,
  output logic              dbin_o,
  output logic              wr_no,
  output logic              wait_o,
  output logic              hlda_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [KIND_W-1:0] kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] status;
  logic              rd_cls, wr_cls, hold_pend;
  tstate_e           state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= K_MEM_RD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (req_take_o) begin
      kind_q  <= req_kind_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  bus_cycle_decode u_dec (
    .kind_i  (kind_q),
    .status_o(status),
    .rd_cls_o(rd_cls),
    .wr_cls_o(wr_cls)
  );

  bus_tstate_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .halt_i     (halt_i),
    .ready_i    (ready_i),
    .hold_i     (hold_i),
    .state_o    (state),
    .hold_pend_o(hold_pend),
    .take_o     (req_take_o)
  );

  bus_pin_drive #(.ADDR_W(ADDR_W)) u_drv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .hold_pend_i(hold_pend),
    .rd_cls_i   (rd_cls),
    .wr_cls_i   (wr_cls),
    .status_i   (status),
    .addr_i     (addr_q),
    .wdata_i    (wdata_q),
    .data_i     (data_i),
    .addr_o     (addr_o),
    .addr_oe_o  (addr_oe_o),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o),
    .sync_o     (sync_o),
    .dbin_o     (dbin_o),
    .wr_no      (wr_no),
    .wait_o     (wait_o),
    .hlda_o     (hlda_o),
    .done_o     (done_o),
    .rdata_o    (rdata_o)
  );

  AST_SYNC_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o) else $error("sync width"); // R1
  AST_SYNC_AFTER_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_take_o |=> sync_o) else $error("sync after take"); // R1
  AST_WAIT_ON_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> !$past(ready_i)) else $error("wait w/o stall"); // R3
  AST_DBIN_NOT_DRIVING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbin_o |-> (!data_oe_o && wr_no)) else $error("dbin contention"); // R4
  AST_WR_BUS_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (data_oe_o && addr_oe_o)) else $error("wr undriven"); // R5
  AST_WR_DATA_SET_BEFORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) |-> ($past(data_oe_o) && $stable(data_o))) else $error("wr data"); // R5
  AST_HELD_BUS_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!addr_oe_o && !data_oe_o && wr_no)) else $error("held drive"); // R8
  AST_HELD_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!req_take_o && !sync_o)) else $error("held start"); // R8
  AST_RELEASE_STAYS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hlda_o) |-> !addr_oe_o) else $error("early drive"); // R9
endmodule

// File: tb/bus_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic [3:0] req_kind_i = 4'd0;
  logic [15:0] req_addr_i = 16'h0;
  logic [7:0] req_wdata_i = 8'h0;
  logic       halt_i = 1'b0;
  logic       ready_i = 1'b1;
  logic       hold_i = 1'b0;
  logic [7:0] data_i = 8'h0;
  logic       req_take_o, addr_oe_o, data_oe_o, sync_o, dbin_o, wr_no, wait_o, hlda_o, done_o;
  logic [15:0] addr_o;
  logic [7:0] data_o, rdata_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  bus_cycle_ctrl dut_i (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input int k);
    case (k)
      0: return 8'hA0; 1: return 8'h80; 2: return 8'h02; 3: return 8'h40;
      4: return 8'h10; 5: return 8'h84; 6: return 8'h06; 7: return 8'h21;
      8: return 8'h88; default: return 8'h80;
    endcase
  endfunction

  function automatic bit is_wr(input int k);
    return (k == 2) || (k == 4) || (k == 6);
  endfunction

  // monitor: bus never used while released
  int mon_bad = 0;
  logic prev_wr = 1'b1;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (hlda_o && (sync_o || req_take_o)) begin
        mon_bad++;
        $display("FAIL R8 monitor: transfer start under hlda actual=1 expected=0");
      end
      if (prev_wr && !wr_no && !addr_oe_o) begin
        mon_bad++;
        $display("FAIL R8 monitor: wr fell with address floating actual=0 expected=1");
      end
    end
    prev_wr = wr_no;
  end

  // hmode: 0 none, 1 granted, 2 only idle/T1, 3 only while stalled
  task automatic run_cycle(input int kind, input logic [15:0] addr, input logic [7:0] wd,
                           input int nwait, input int hmode, input logic [7:0] rdv);
    bit rd = !is_wr(kind);
    bit granted = (hmode == 1);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_kind_i = 4'(kind); req_addr_i = addr; req_wdata_i = wd;
    hold_i = (hmode == 2);
    @(negedge clk_i);  // T1
    chk(sync_o == 1'b1, "R1", "sync in T1", sync_o, 1);
    chk(addr_oe_o && addr_o == addr, "R1", "address in T1", addr_o, addr);
    chk(data_oe_o && data_o == exp_status(kind), "R2", "status byte", data_o, exp_status(kind));
    chk(hlda_o == 1'b0, "R6", "hlda in T1", hlda_o, 0);
    req_valid_i = 1'b0;
    ready_i = (nwait == 0);
    hold_i = (hmode == 1) || (hmode == 3);
    for (int j = 0; j <= nwait; j++) begin
      @(negedge clk_i);  // T2 then TW
      chk(sync_o == 1'b0, "R1", "sync after T1", sync_o, 0);
      chk(wait_o == (j > 0), "R3", "wait flag", wait_o, (j > 0));
      chk(dbin_o == rd, "R4", "dbin in T2/TW", dbin_o, rd);
      if (!rd) chk(data_oe_o && data_o == wd && wr_no, "R5", "write data early",
                   data_o, wd);
      if (j == nwait) begin
        ready_i = 1'b1;
        if (hmode == 3) hold_i = 1'b0;
      end
    end
    @(negedge clk_i);  // T3
    chk(wait_o == 1'b0, "R3", "wait ends", wait_o, 0);
    chk(wr_no == rd, "R5", "wr strobe in T3", wr_no, rd);
    chk(hlda_o == (granted && rd), "R7", "hlda in T3", hlda_o, granted && rd);
    if (rd) begin
      data_i = rdv;
      chk(dbin_o == 1'b1, "R4", "dbin in T3", dbin_o, 1);
      if (granted) chk(addr_oe_o == 1'b0, "R8", "addr float T3", addr_oe_o, 0);
    end else begin
      chk(data_oe_o && data_o == wd, "R5", "write data T3", data_o, wd);
    end
    @(negedge clk_i);  // after T3
    chk(done_o == 1'b1, "R4", "done pulse", done_o, 1);
    if (rd) chk(rdata_o == rdv, "R4", "read data", rdata_o, rdv);
    chk(hlda_o == granted, "R7", "hlda after T3", hlda_o, granted);
    chk(wr_no == 1'b1, "R5", "wr released", wr_no, 1);
    if (granted) begin
      chk(!addr_oe_o && !data_oe_o, "R8", "bus float", addr_oe_o, 0);
      req_valid_i = 1'b1;  // request while held
      @(negedge clk_i);
      chk(hlda_o && !req_take_o && !sync_o, "R8", "no start while held",
          req_take_o, 0);
      hold_i = 1'b0; req_valid_i = 1'b0;
      @(negedge clk_i);
      chk(hlda_o == 1'b0, "R9", "hlda released", hlda_o, 0);
      chk(addr_oe_o == 1'b0, "R9", "drivers off until T1", addr_oe_o, 0);
    end
    hold_i = 1'b0;
  endtask

  task automatic test_reset;
    chk(hlda_o == 0 && addr_oe_o == 0 && data_oe_o == 0 && wr_no == 1 && sync_o == 0,
        "R10", "reset state", {hlda_o, addr_oe_o, data_oe_o, wr_no}, 4'b0001);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic test_status_all;
    for (int k = 0; k <= 8; k++)
      run_cycle(k, 16'h1000 + 16'(k), 8'h30 + 8'(k), 0, 0, 8'h5A ^ 8'(k));
  endtask

  task automatic test_waits;
    run_cycle(1, 16'hBEEF, 8'h00, 3, 0, 8'hC3);  // R3 read stall
    run_cycle(2, 16'h0042, 8'h99, 2, 0, 8'h00);  // R3 write stall
  endtask

  task automatic test_hold_grant;
    run_cycle(3, 16'h00F0, 8'h00, 0, 1, 8'h11);  // R7 read: hlda at T3
    run_cycle(4, 16'h00F1, 8'h77, 0, 1, 8'h00);  // R7 write: hlda after T3
    run_cycle(5, 16'hFFFE, 8'h00, 2, 1, 8'h22);
    run_cycle(6, 16'hFFFD, 8'h44, 1, 1, 8'h00);
    run_cycle(0, 16'h0100, 8'h00, 0, 1, 8'hE1);  // R9 resume
  endtask

  task automatic test_hold_ignored;
    @(negedge clk_i);
    hold_i = 1'b1;
    repeat (3) begin
      @(negedge clk_i);
      chk(hlda_o == 1'b0, "R6", "hold in idle ignored", hlda_o, 0);
    end
    hold_i = 1'b0;
    run_cycle(1, 16'h2222, 8'h00, 0, 2, 8'h33);  // R6 idle/T1 only
    run_cycle(2, 16'h2223, 8'h66, 0, 2, 8'h00);
    run_cycle(1, 16'h2224, 8'h00, 3, 3, 8'h34);  // R6 stall only
    run_cycle(4, 16'h2225, 8'h67, 2, 3, 8'h00);
  endtask

  task automatic test_halt_hold;
    @(negedge clk_i);
    halt_i = 1'b1;
    @(negedge clk_i);
    chk(hlda_o == 1'b0 && sync_o == 1'b0, "R11", "halted no hlda", hlda_o, 0);
    hold_i = 1'b1;
    @(negedge clk_i);
    chk(hlda_o == 1'b1, "R11", "hold while halted", hlda_o, 1);
    chk(!addr_oe_o && !data_oe_o, "R8", "float while halted-held", addr_oe_o, 0);
    halt_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(hlda_o == 1'b0, "R10", "reset clears hlda", hlda_o, 1'b0);
    hold_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    run_cycle(0, 16'h0000, 8'h00, 0, 0, 8'h00);
  endtask

  task automatic test_random;
    for (int n = 0; n < 40; n++) begin
      int k  = int'($urandom_range(0, 8));
      int nw = int'($urandom_range(0, 4));
      int hm = int'($urandom_range(0, 3));
      if (hm == 3 && nw == 0) hm = 0;
      run_cycle(k, 16'($urandom), 8'($urandom), nw, hm, 8'($urandom));
    end
    chk(mon_bad == 0, "R8", "monitor violations", mon_bad, 0);
  endtask

  initial begin
    #5;
    test_reset();
    test_status_all();
    test_waits();
    test_hold_grant();
    test_hold_ignored();
    test_halt_hold();
    test_random();
    repeat (2) @(negedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule